// File: doc/BRIEF.md
# Program Status Polling Read Path

This block sits on the host read path of a sector-programmed flash array. It decides what each host read returns. While an internal program cycle is running, the array cannot supply stored data, so a read returns a status byte built from the last byte loaded. That byte carries two progress indicators. The data-polling bit is the inverted top bit of the loaded byte. The toggle bit changes state on each successive read. When the cycle ends, reads return the true array contents again, and the toggle bit stops moving.

The host control lines (chip enable, output enable and write enable, all active low) are sampled on the block clock. A read strobe counts as present when chip enable and output enable are low and write enable is high. Only the leading edge of a strobe produces a result, so a strobe held for many cycles yields exactly one. A write attempt that starts the program timer without the unlock prefix also raises the busy flag, so reads during that period are status polls in the same way. The program timer and the output-drive control belong to neighbouring blocks.

Top module: `poll_read_path`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, and the toggle state is 0, so the first status read of a cycle shows 0 in bit 6.
- R2: A read strobe is `ce_n`=0, `oe_n`=0 and `we_n`=1. Each rising edge of the strobe yields exactly one result, however long the strobe is held. Inputs with `we_n`=0 or `ce_n`=1 yield no result.
- R3: With `busy` low, a read returns `array_rdata` on all 8 bits.
- R4: With `busy` high and `addr` equal to `ld_addr`, bit 7 of the result is the inverse of bit 7 of `ld_data`.
- R5: With `busy` high, bit 6 of the result is the toggle state, which then inverts. Reads within one cycle therefore give 0, 1, 0, 1 and so on.
- R6: With `busy` high, bits 5 to 0 of the result equal bits 5 to 0 of `ld_data`, whatever the address.
- R7: With `busy` high and `addr` different from `ld_addr`, bit 7 of the result is 0.
- R8: The toggle state returns to 0 at the start of every program cycle (a rising edge of `busy`), even if the previous cycle saw an odd number of reads.
- R9: With `busy` low, reads do not change the toggle state, and the result carries no status bits.
- R10: `rd_valid` is a one-cycle pulse. It rises on the clock edge that follows the strobe's first sampled cycle, with `rd_data` valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Host chip enable, active low, already synchronised |
| oe_n | input | 1 | Host output enable, active low, already synchronised |
| we_n | input | 1 | Host write enable, active low, already synchronised |
| addr | input | AW (17) | Host read address |
| array_rdata | input | DW (8) | Array data for `addr` |
| busy | input | 1 | Internal program cycle in progress |
| ld_addr | input | AW (17) | Address of the last byte loaded |
| ld_data | input | DW (8) | Value of the last byte loaded |
| rd_data | output | DW (8) | Read result |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_data` |

## Verification
The hardest case is a toggle reset that can actually be seen. The previous cycle must end with the toggle at 1 after an odd number of polls, and the next cycle's first poll must then show 0. The stimulus runs three polls in one busy period, then an idle read, then raises `busy` again and polls once. A second hard case is a strobe held for several cycles and a strobe disqualified by `we_n` or `ce_n`. Both are checked by comparing the number of result pulses with the number of strobe edges the scoreboard expects.

// File: rtl/poll_pkg.sv
// Shared types for the program status polling read path.
// Assumes an 8-bit-or-wider data path with the poll and toggle
// bits placed at positions chosen by the top-level parameters.
package poll_pkg;
    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_STATUS = 1'b1
    } rd_src_e;
endpackage

// File: rtl/poll_strobe_detect.sv
// Read strobe qualifier and leading-edge detector.
// Assumes the host control lines are already synchronised to clk.
// Produces a one-cycle pulse on the first cycle a read strobe is seen.
module poll_strobe_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rise
);
    logic strobe;
    logic strobe_q;

    // Qualify the read: chip and output enabled, no write in progress.
    always_comb strobe = !ce_n && !oe_n && we_n;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Leading edge of the strobe.
    always_comb rise = strobe && !strobe_q;
endmodule

// File: rtl/poll_toggle.sv
// Toggle-bit state for status polling.
// Cleared on each rising edge of busy; inverted on every read edge
// while busy. tog_now is the value a read in this cycle must report.
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rise,
    output logic tog_now
);
    logic busy_q;
    logic tog;
    logic start;

    // Track busy to find the start of a program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // A new program cycle begins this clock.
    always_comb start = busy && !busy_q;

    // Value reported by a read this cycle (a cycle start forces 0).
    always_comb tog_now = start ? 1'b0 : tog;

    // Advance the toggle on each busy read; clear at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (start)
            tog <= rise;
        else if (busy && rise)
            tog <= !tog;
    end

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_q && rise) |=> (tog != $past(tog)));   // R5
    AST_TOG_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_q && !rise) |=> !tog);                 // R8
    AST_TOG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog));                              // R9
endmodule

// File: rtl/poll_status_mux.sv
// Builds the status byte and registers the read result.
// Assumes array_rdata is valid for the current address in the cycle
// the strobe edge is seen. The status bit layout is chosen per bit
// by generate from POLL_BIT and TOG_BIT.
module poll_status_mux #(
    parameter int DW       = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          busy,
    input  logic          hit,
    input  logic          tog_now,
    input  logic [DW-1:0] ld_data,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    import poll_pkg::*;

    logic [DW-1:0] status;
    rd_src_e       src;

    // Assemble the status byte one bit at a time.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign status[i] = hit ? !ld_data[i] : 1'b0;
        end else if (i == TOG_BIT) begin : g_tog
            assign status[i] = tog_now;
        end else begin : g_copy
            assign status[i] = ld_data[i];
        end
    end

    // Busy cycles report status; otherwise the array answers.
    always_comb src = busy ? SRC_STATUS : SRC_ARRAY;

    // Capture a result on each strobe edge and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rise;
            if (rise) rd_data <= (src == SRC_STATUS) ? status : array_rdata;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                        // R10
    AST_IDLE_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(busy)) |-> (rd_data == $past(array_rdata))); // R3
    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy) && $past(hit))
            |-> (rd_data[POLL_BIT] == !$past(ld_data[POLL_BIT])));       // R4
    AST_POLL_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy) && !$past(hit)) |-> !rd_data[POLL_BIT]); // R7
    AST_LOW_BITS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy))
            |-> (rd_data[TOG_BIT-1:0] == $past(ld_data[TOG_BIT-1:0])));  // R6
endmodule

// File: rtl/poll_read_path.sv
// Program status polling read path, top level.
// Assumes synchronised host controls and a combinational array read.
// Returns either true array data or a progress status byte on each
// host read strobe edge, depending on the busy flag.
module poll_read_path #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] array_rdata,
    input  logic          busy,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic rise;
    logic tog_now;
    logic hit;

    // The read targets the byte whose program cycle is running.
    always_comb hit = (addr == ld_addr);

    poll_strobe_detect u_strobe (
        .clk  (clk),
        .rst_n(rst_n),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .rise (rise)
    );

    poll_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .rise   (rise),
        .tog_now(tog_now)
    );

    poll_status_mux #(
        .DW      (DW),
        .POLL_BIT(POLL_BIT),
        .TOG_BIT (TOG_BIT)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .busy       (busy),
        .hit        (hit),
        .tog_now    (tog_now),
        .ld_data    (ld_data),
        .array_rdata(array_rdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );
endmodule

// File: tb/poll_read_path_bench.sv
module poll_read_path_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0, ld_addr = '0;
    logic [DW-1:0] array_rdata = '0, ld_data = '0;
    logic          busy = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int tests = 0, fails = 0;
    int exp_cnt = 0, got_cnt = 0;
    bit model_tog = 1'b0;
    bit done = 1'b0;

    logic [DW-1:0] q_exp[$];
    string         q_tag[$];

    always #(CLK_PERIOD/2) clk = !clk;

    poll_read_path #(.AW(AW), .DW(DW)) u_poll_read_path (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .array_rdata(array_rdata), .busy(busy),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected item for every result pulse.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            got_cnt++;
            if (q_exp.size() == 0) begin
                check(1'b0, "R2 unexpected result", rd_data, 0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic set_busy(input bit v);
        @(negedge clk);
        if (v && !busy) model_tog = 1'b0;
        busy = v;
    endtask

    // Driver: one qualified read, held for 'hold' cycles; pushes the expectation.
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] arr, input int hold, input string tag);
        logic [DW-1:0] e;
        @(negedge clk);
        addr = a; array_rdata = arr;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        if (busy) begin
            e = {(a == ld_addr) ? !ld_data[7] : 1'b0, model_tog, ld_data[5:0]};
            model_tog = !model_tog;
        end else begin
            e = arr;
        end
        q_exp.push_back(e); q_tag.push_back(tag); exp_cnt++;
        repeat (hold) @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

        // Idle reads return array data (R3, R10).
        do_read(17'h00010, 8'hA5, 1, "R3 idle read A5");
        do_read(17'h1FFF0, 8'h3C, 1, "R3 idle read 3C / R10");

        // Program cycle, polling the loaded byte.
        ld_addr = 17'h00123; ld_data = 8'h96;
        set_busy(1'b1);
        do_read(17'h00123, 8'h00, 1, "R1 R4 R5 first poll");
        do_read(17'h00123, 8'hFF, 1, "R4 R5 R6 second poll");
        do_read(17'h00055, 8'h77, 1, "R7 R6 poll other addr");
        set_busy(1'b0);
        do_read(17'h00123, 8'h96, 1, "R9 true data after busy");
        do_read(17'h00123, 8'h5A, 1, "R9 idle read no status");

        // New cycle after an odd number of polls: toggle starts at 0 (R8).
        ld_addr = 17'h00200; ld_data = 8'h41;
        set_busy(1'b1);
        do_read(17'h00200, 8'hEE, 1, "R8 toggle cleared");
        do_read(17'h00200, 8'hEE, 4, "R2 R5 held strobe");
        do_read(17'h00201, 8'hEE, 1, "R7 miss bit7 zero");
        set_busy(1'b0);

        // Non-qualifying strobes: no result (R2).
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        oe_n = 1'b1; we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        oe_n = 1'b1;
        repeat (3) @(negedge clk);
        check(got_cnt == exp_cnt, "R2 result count", got_cnt, exp_cnt);
        check(q_exp.size() == 0, "R10 no pending result", q_exp.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule